// File: doc/BRIEF.md
# Time-Aligned Square-Wave Pin Generator

This block drives one output pin with a 50% duty-cycle square wave whose edges fall on absolute instants of a shared 64-bit tick counter. The counter comes from a separate clock block as a plain input. Software programs an absolute start instant and a half-period, both counted in ticks. It then pulses an arm strobe to start the wave or a halt strobe to stop it.

An arm request is honoured only if the start instant is still in the future and the half-period is non-zero. Any other arm request leaves the block exactly as it was. Once armed, the pin rises when the time first reaches the start instant. Each later edge is placed one half-period after the previous scheduled instant, so the phase stays tied to absolute time when the counter is stepped. There is no data stream, so every pin is a plain control or status signal with no handshake. To trim the output frequency, change the tick rate of the clock block that supplies the time.

Top module: `ptp_wave_gen`

## Requirements
- R1: After reset the block is idle and `wave_out` is low.
- R2: `go_pulse` is accepted only when `arm_time` is strictly greater than the `now_ticks` value sampled in the same cycle. If `arm_time` is equal to or less than that value, the request changes nothing: an idle block stays idle and low, and a running block keeps its current schedule.
- R3: An arm request with `half_ticks` equal to zero is ignored in the same way.
- R4: After an accepted arm, `wave_out` is low. Its first transition is a rise, seen in the cycle after the first clock edge at which `now_ticks` is equal to or greater than `arm_time`.
- R5: Edge k (k = 0, 1, 2, ...) is scheduled at `arm_time + k*half_ticks`. When the time advances by one tick per cycle, each high level and each low level lasts exactly `half_ticks` cycles.
- R6: `halt_pulse` forces `wave_out` low and idle in the next cycle, and no further edges follow. If both strobes are asserted in the same cycle, the halt takes effect.
- R7: If the time steps backwards, `wave_out` holds its level until the time reaches the next scheduled instant again. If the time steps forward past several scheduled instants, the missed edges are issued one per cycle until the schedule catches up.
- R8: An accepted arm while running discards the old schedule. `wave_out` goes low in the next cycle and follows the new schedule.
- R9: While idle, `wave_out` stays low whatever `now_ticks` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| now_ticks | input | 64 | Current time from the clock block, in ticks |
| arm_time | input | 64 | Absolute instant of the first (rising) edge |
| half_ticks | input | 32 | Ticks between successive edges (half the period) |
| go_pulse | input | 1 | One-cycle arm request |
| halt_pulse | input | 1 | One-cycle stop request |
| wave_out | output | 1 | Square-wave output pin |

## Verification
The only visible state is the level of `wave_out`. A wrong internal value therefore shows up as an edge in the wrong cycle. A corrupted next-edge instant or a stale half-period moves the next transition by at least one cycle. A wrongly set armed flag produces a transition while the block should be idle, or a missing rise once the start instant has passed. A forward or backward time step exposes a schedule that follows the current time instead of the previous scheduled instant: the pin level then differs within a few cycles of the step. Because of this, the pin is compared against an arithmetic expectation on every cycle.

// File: rtl/ptp_wave_pkg.sv
package ptp_wave_pkg;
  // one command per cycle, decided by the arming logic
  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_LOAD = 2'd1,
    CMD_HALT = 2'd2
  } wave_cmd_e;
endpackage

// File: rtl/wave_arm_ctrl.sv
module wave_arm_ctrl
  import ptp_wave_pkg::*;
#(
  parameter int TIME_W = 64,
  parameter int DUR_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] now_ticks,
  input  logic [TIME_W-1:0] arm_time,
  input  logic [DUR_W-1:0]  half_ticks,
  input  logic              go_pulse,
  input  logic              halt_pulse,
  output wave_cmd_e         cmd,
  output logic              armed
);
  logic in_future;
  logic dur_ok;
  logic accept;

  assign in_future = arm_time > now_ticks;
  assign dur_ok    = |half_ticks;
  assign accept    = go_pulse && in_future && dur_ok;

  always_comb begin
    if (halt_pulse)  cmd = CMD_HALT;
    else if (accept) cmd = CMD_LOAD;
    else             cmd = CMD_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                armed <= 1'b0;
    else if (cmd == CMD_HALT)  armed <= 1'b0;
    else if (cmd == CMD_LOAD)  armed <= 1'b1;
  end

  // R2: a request for an instant already reached leaves an idle block idle
  p_late_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (go_pulse && !halt_pulse && !armed && arm_time <= now_ticks) |=> !armed);

  // R3: zero half-period never arms
  p_zero_dur_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (go_pulse && !halt_pulse && !armed && half_ticks == '0) |=> !armed);

  // R6: halt always disarms
  p_halt_disarms_r6: assert property (@(posedge clk) disable iff (!rst_n)
    halt_pulse |=> !armed);
endmodule

// File: rtl/wave_edge_sched.sv
module wave_edge_sched
  import ptp_wave_pkg::*;
#(
  parameter int TIME_W = 64,
  parameter int DUR_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] now_ticks,
  input  logic [TIME_W-1:0] arm_time,
  input  logic [DUR_W-1:0]  half_ticks,
  input  wave_cmd_e         cmd,
  input  logic              armed,
  output logic              fire
);
  localparam int PAD_W = TIME_W - DUR_W;

  logic [TIME_W-1:0] next_edge;
  logic [DUR_W-1:0]  step_q;
  logic [TIME_W-1:0] step_ext;

  assign step_ext = {{PAD_W{1'b0}}, step_q};
  assign fire     = armed && (now_ticks >= next_edge);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_edge <= '0;
      step_q    <= '0;
    end else if (cmd == CMD_LOAD) begin
      next_edge <= arm_time;
      step_q    <= half_ticks;
    end else if (cmd == CMD_NONE && fire) begin
      // advance from the scheduled instant, not from the current time
      next_edge <= next_edge + step_ext;
    end
  end

  // R5: each fired edge moves the schedule by exactly one half-period
  p_sched_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cmd == CMD_NONE) |=> next_edge == $past(next_edge) + $past(step_ext));

  // R7: without a fired edge or a command the schedule is frozen
  p_sched_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && cmd == CMD_NONE) |=> $stable(next_edge) && $stable(step_q));
endmodule

// File: rtl/wave_pin_drive.sv
module wave_pin_drive
  import ptp_wave_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  wave_cmd_e cmd,
  input  logic      fire,
  input  logic      armed,
  output logic      pin
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        pin <= 1'b0;
    else if (cmd != CMD_NONE)          pin <= 1'b0;
    else if (fire)                     pin <= ~pin;
  end

  // R1: leaving reset the pin is low
  p_reset_low_r1: assert property (@(posedge clk) $rose(rst_n) |-> !pin);

  // R6: halt forces the pin low
  p_halt_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_HALT) |=> !pin);

  // R8: an accepted arm restarts from low
  p_load_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_LOAD) |=> !pin);

  // R9: an idle block never shows a high pin
  p_idle_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !pin);

  // R4: the pin moves only on a scheduled edge or a command
  p_no_spurious_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_NONE && !fire) |=> $stable(pin));
endmodule

// File: rtl/ptp_wave_gen.sv
module ptp_wave_gen
  import ptp_wave_pkg::*;
#(
  parameter int TIME_W = 64,
  parameter int DUR_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] now_ticks,
  input  logic [TIME_W-1:0] arm_time,
  input  logic [DUR_W-1:0]  half_ticks,
  input  logic              go_pulse,
  input  logic              halt_pulse,
  output logic              wave_out
);
  wave_cmd_e cmd;
  logic      armed;
  logic      fire;

  wave_arm_ctrl #(.TIME_W(TIME_W), .DUR_W(DUR_W)) u_arm (
    .clk        (clk),
    .rst_n      (rst_n),
    .now_ticks  (now_ticks),
    .arm_time   (arm_time),
    .half_ticks (half_ticks),
    .go_pulse   (go_pulse),
    .halt_pulse (halt_pulse),
    .cmd        (cmd),
    .armed      (armed)
  );

  wave_edge_sched #(.TIME_W(TIME_W), .DUR_W(DUR_W)) u_sched (
    .clk        (clk),
    .rst_n      (rst_n),
    .now_ticks  (now_ticks),
    .arm_time   (arm_time),
    .half_ticks (half_ticks),
    .cmd        (cmd),
    .armed      (armed),
    .fire       (fire)
  );

  wave_pin_drive u_pin (
    .clk   (clk),
    .rst_n (rst_n),
    .cmd   (cmd),
    .fire  (fire),
    .armed (armed),
    .pin   (wave_out)
  );
endmodule

// File: tb/test_ptp_wave_gen.sv
module test_ptp_wave_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] now_ticks = 64'd1000;
  logic [63:0] arm_time = '0;
  logic [31:0] half_ticks = '0;
  logic        go_pulse = 1'b0;
  logic        halt_pulse = 1'b0;
  logic        wave_out;

  int n_cmp = 0;
  int n_bad = 0;

  // expected state from the requirements
  logic        m_armed = 1'b0;
  logic [63:0] m_start = '0;
  logic [63:0] m_dur = 64'd1;
  logic [63:0] m_fired = '0;
  logic        m_pin = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptp_wave_gen i_ptp_wave_gen (
    .clk(clk), .rst_n(rst_n), .now_ticks(now_ticks), .arm_time(arm_time),
    .half_ticks(half_ticks), .go_pulse(go_pulse), .halt_pulse(halt_pulse),
    .wave_out(wave_out)
  );

  // number of scheduled instants at or before t (R5)
  function automatic logic [63:0] due_edges(input logic [63:0] t);
    if (t < m_start) return 64'd0;
    return (t - m_start) / m_dur + 64'd1;
  endfunction

  task automatic check_pin(input string tag);
    n_cmp++;
    if (wave_out !== m_pin) begin
      n_bad++;
      $display("FAIL %s: wave_out=%0b expected %0b (now=%0d)", tag, wave_out, m_pin, now_ticks);
    end
  endtask

  // one clock: advance the model with the inputs the edge saw, compare, default next inputs
  task automatic cycle(input string tag);
    @(negedge clk);
    if (!rst_n) begin
      m_armed = 1'b0; m_fired = '0;
    end else if (halt_pulse) begin
      m_armed = 1'b0; m_fired = '0;
    end else if (go_pulse && arm_time > now_ticks && half_ticks != 0) begin
      m_armed = 1'b1; m_start = arm_time; m_dur = {32'd0, half_ticks}; m_fired = '0;
    end else if (m_armed && due_edges(now_ticks) > m_fired) begin
      m_fired = m_fired + 64'd1;   // at most one edge per cycle (R7)
    end
    m_pin = m_armed & m_fired[0];
    check_pin(tag);
    go_pulse = 1'b0;
    halt_pulse = 1'b0;
    now_ticks = now_ticks + 64'd1;
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) cycle(tag);
  endtask

  task automatic arm(input logic [63:0] t, input logic [31:0] d, input string tag);
    arm_time = t; half_ticks = d; go_pulse = 1'b1;
    cycle(tag);
  endtask

  task automatic halt(input string tag);
    halt_pulse = 1'b1;
    cycle(tag);
  endtask

  initial begin
    run(3, "R1");
    rst_n = 1'b1;
    cycle("R1");
    // R1: explicit reset state
    n_cmp++;
    if (wave_out !== 1'b0) begin
      n_bad++; $display("FAIL R1: wave_out=%0b expected 0", wave_out);
    end

    run(12, "R9");                                 // idle, time running

    arm(now_ticks, 32'd3, "R2");                   // equal instant: ignored
    run(10, "R2");
    arm(now_ticks - 64'd5, 32'd3, "R2");           // past instant: ignored
    run(10, "R2");
    arm(now_ticks + 64'd2, 32'd0, "R3");           // zero half-period: ignored
    run(12, "R3");

    // R4/R5 sweep over half-periods and start offsets
    for (int d = 1; d <= 6; d++) begin
      for (int off = 1; off <= 5; off++) begin
        arm(now_ticks + 64'(off), 32'(d), "R4");
        run(off + 1, "R4");
        run(6 * d + 3, "R5");
        halt("R6");
        run(3, "R6");
      end
    end

    // R2: stale request while running keeps the schedule
    arm(now_ticks + 64'd2, 32'd4, "R5");
    run(9, "R5");
    arm(now_ticks - 64'd1, 32'd2, "R2");
    run(14, "R2");

    // R7: backward step, then forward step with catch-up
    now_ticks = now_ticks - 64'd7;
    run(20, "R7");
    now_ticks = now_ticks + 64'd13;
    run(20, "R7");

    // R8: re-arm while running
    arm(now_ticks + 64'd3, 32'd2, "R8");
    run(15, "R8");

    // R6: halt and arm together, halt wins
    arm_time = now_ticks + 64'd2; half_ticks = 32'd2;
    go_pulse = 1'b1; halt_pulse = 1'b1;
    cycle("R6");
    run(10, "R6");
    // R9: idle after halt despite time jumps
    now_ticks = now_ticks + 64'd500;
    run(8, "R9");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not end, actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule